// File: doc/BRIEF.md
# Packed 64-bit SIMD Execution Unit

This block is a two-stage pipelined execution unit for 64-bit packed-integer arithmetic. Each cycle it may accept one already-decoded operation. The operation comes with two 64-bit vector operands, a 32-bit integer operand and an 8-bit immediate. The destination operand is the first vector operand. The second vector operand is the source, whether it came from a register or from memory. Exactly two clock edges after issue, the block presents the 64-bit result with a valid flag. A 32-bit result is zero-extended to 64 bits.

The operations are:
- signed greater-than compares that build lane masks, on 16-bit or 32-bit lanes;
- lane-wise maxima, signed on 16-bit words or unsigned on bytes;
- extraction and insertion of one 16-bit word chosen by the immediate;
- a multiply-add that sums pairs of signed 16x16 products into two 32-bit lanes.

The surrounding core fetches operands, forms memory addresses and writes results back. The unit itself holds no architectural state. It has no back-pressure, so a new operation can be issued on every cycle.

Top module: `simd_exec`

## Requirements
- R1: Operation code 1 (dword compare): each 32-bit lane i (bits 32i+31..32i) of the result is FFFF_FFFFh when the destination lane is greater than the source lane as signed two's-complement numbers, and 0000_0000h otherwise.
- R2: Operation code 0 (word compare): each 16-bit lane of the result is FFFFh when the destination word is greater than the source word as signed numbers, and 0000h otherwise.
- R3: Operation code 2 (signed word maximum): each 16-bit lane of the result is the destination word if it is signed-greater than the source word, otherwise the source word.
- R4: Operation code 3 (unsigned byte maximum): each 8-bit lane of the result is the destination byte if it is unsigned-greater than the source byte, otherwise the source byte.
- R5: Operation code 4 (word extract): result bits 15..0 are word number inImm[1:0] of inSrc, where word n is bits 16n+15..16n. Result bits 63..16 are zero. inImm[7:2] has no effect.
- R6: Operation code 5 (word insert): the result is inDst with word number inImm[1:0] replaced by inInt[15:0]; the other three words are unchanged. inImm[7:2] and inInt[31:16] have no effect.
- R7: Operation code 6 (multiply-add): result bits 31..0 are the signed products of words 0 and 1 of inDst and inSrc, summed. Result bits 63..32 are the same sum for words 2 and 3. Each sum wraps modulo 2^32, so four 8000h inputs give 8000_0000h.
- R8: An operation issued with inValid high at a rising edge appears with outValid high after the second following rising edge. An edge with inValid low yields outValid low two edges later. Back-to-back issue is supported at one operation per cycle.
- R9: rst is synchronous and active high. At an edge where rst is high, both pipeline stages are emptied, so outValid and outResult read zero after that edge, and any operation presented at that edge is discarded.
- R10: Operation code 7 is reserved: it completes with outValid high and an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | An operation is issued this cycle |
| inOp | input | 3 | Decoded operation code (see R1 to R10) |
| inDst | input | 64 | Destination vector operand |
| inSrc | input | 64 | Source vector operand (register or memory) |
| inInt | input | 32 | Integer operand for word insert |
| inImm | input | 8 | Immediate; low two bits select a word |
| outValid | output | 1 | Result valid |
| outResult | output | 64 | Result, zero-extended for 32-bit results |

## Verification
On every cycle, the bound checker follows the fixed two-edge latency and the reset clearing. It also checks several shape properties of each retired result: compare lanes are solid masks, each maximum lane is one of its two inputs and no smaller than either, extract results have zero upper bits, and reserved codes produce zero. Only the bench scenarios show the exact values. These are the word chosen by the immediate for insert and extract, the signed-versus-unsigned boundary cases around 8000h and FFh, and the wrapping multiply-add sum. The bench compares each of these against a model written from the requirements, under random mixed traffic with idle gaps and a mid-stream reset.

// File: rtl/simd_exec_pkg.sv
package simd_exec_pkg;

  parameter int DATA_W  = 64;
  parameter int WORD_W  = 16;
  parameter int DWORD_W = 32;
  parameter int BYTE_W  = 8;
  parameter int INT_W   = 32;
  parameter int IMM_W   = 8;
  parameter int OP_W    = 3;

  parameter int NUM_WORDS  = DATA_W / WORD_W;
  parameter int NUM_DWORDS = DATA_W / DWORD_W;
  parameter int NUM_BYTES  = DATA_W / BYTE_W;
  parameter int IDX_W      = $clog2(NUM_WORDS);
  parameter int PROD_W     = 2 * WORD_W;

  typedef enum logic [OP_W-1:0] {
    OP_CMPGT_W  = 3'd0,
    OP_CMPGT_D  = 3'd1,
    OP_MAX_SW   = 3'd2,
    OP_MAX_UB   = 3'd3,
    OP_EXTRACT  = 3'd4,
    OP_INSERT   = 3'd5,
    OP_MADD     = 3'd6,
    OP_RESERVED = 3'd7
  } simdOp_e;

  // One-hot result selection; all zero means a zero result.
  typedef struct packed {
    logic cmpW;
    logic cmpD;
    logic maxS;
    logic maxU;
    logic ext;
    logic ins;
    logic madd;
  } simdSel_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic     capture;  // load stage-1 operand registers
    logic     retire;   // load stage-2 result register
    simdSel_t sel;      // stage-2 result selection
  } simdStrb_t;

endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_exec_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  input  logic [OP_W-1:0] inOp,
  output simdStrb_t       strb,
  output logic            outValid
);

  simdSel_t decSel;
  simdSel_t s1Sel;
  logic     s1Valid;
  logic     s2Valid;

  always_comb begin
    decSel = '0;
    unique case (simdOp_e'(inOp))
      OP_CMPGT_W:  decSel.cmpW = 1'b1;
      OP_CMPGT_D:  decSel.cmpD = 1'b1;
      OP_MAX_SW:   decSel.maxS = 1'b1;
      OP_MAX_UB:   decSel.maxU = 1'b1;
      OP_EXTRACT:  decSel.ext  = 1'b1;
      OP_INSERT:   decSel.ins  = 1'b1;
      OP_MADD:     decSel.madd = 1'b1;
      OP_RESERVED: decSel      = '0;
      default:     decSel      = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Sel   <= '0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= inValid;
      if (inValid) s1Sel <= decSel;
      s2Valid <= s1Valid;
    end
  end

  always_comb begin
    strb.capture = inValid & ~rst;
    strb.retire  = s1Valid;
    strb.sel     = s1Sel;
  end

  assign outValid = s2Valid;

endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  simdStrb_t         strb,
  input  logic [DATA_W-1:0] inDst,
  input  logic [DATA_W-1:0] inSrc,
  input  logic [INT_W-1:0]  inInt,
  input  logic [IMM_W-1:0]  inImm,
  output logic [DATA_W-1:0] outResult
);

  // Stage-1 lane flags and products, computed from the raw operands
  logic [NUM_WORDS-1:0]  gtW;
  logic [NUM_DWORDS-1:0] gtD;
  logic [NUM_BYTES-1:0]  gtB;
  logic signed [PROD_W-1:0] prod [NUM_WORDS];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign gtW[w] = $signed(inDst[w*WORD_W +: WORD_W]) >
                    $signed(inSrc[w*WORD_W +: WORD_W]);
    assign prod[w] = $signed(inDst[w*WORD_W +: WORD_W]) *
                     $signed(inSrc[w*WORD_W +: WORD_W]);
  end

  for (genvar d = 0; d < NUM_DWORDS; d++) begin : g_dword
    assign gtD[d] = $signed(inDst[d*DWORD_W +: DWORD_W]) >
                    $signed(inSrc[d*DWORD_W +: DWORD_W]);
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign gtB[b] = inDst[b*BYTE_W +: BYTE_W] > inSrc[b*BYTE_W +: BYTE_W];
  end

  // Stage-1 registers
  logic [DATA_W-1:0]     s1Dst;
  logic [DATA_W-1:0]     s1Src;
  logic [WORD_W-1:0]     s1Ins;
  logic [IDX_W-1:0]      s1Idx;
  logic [NUM_WORDS-1:0]  s1GtW;
  logic [NUM_DWORDS-1:0] s1GtD;
  logic [NUM_BYTES-1:0]  s1GtB;
  logic signed [PROD_W-1:0] s1Prod [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (strb.capture) begin
      s1Dst <= inDst;
      s1Src <= inSrc;
      s1Ins <= inInt[WORD_W-1:0];
      s1Idx <= inImm[IDX_W-1:0];
      s1GtW <= gtW;
      s1GtD <= gtD;
      s1GtB <= gtB;
      for (int w = 0; w < NUM_WORDS; w++) s1Prod[w] <= prod[w];
    end
  end

  // Upper immediate and integer bits take no part in any operation.
  logic unusedHi;
  assign unusedHi = ^{inImm[IMM_W-1:IDX_W], inInt[INT_W-1:WORD_W]};

  // Stage-2 candidate results
  logic [DATA_W-1:0] resCmpW, resCmpD, resMaxS, resMaxU;
  logic [DATA_W-1:0] resExt, resIns, resMadd, resNext;
  logic [WORD_W-1:0] extWord;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word2
    assign resCmpW[w*WORD_W +: WORD_W] = {WORD_W{s1GtW[w]}};
    assign resMaxS[w*WORD_W +: WORD_W] = s1GtW[w] ? s1Dst[w*WORD_W +: WORD_W]
                                                  : s1Src[w*WORD_W +: WORD_W];
    assign resIns[w*WORD_W +: WORD_W]  = (s1Idx == IDX_W'(w)) ? s1Ins
                                                  : s1Dst[w*WORD_W +: WORD_W];
  end

  for (genvar d = 0; d < NUM_DWORDS; d++) begin : g_dword2
    assign resCmpD[d*DWORD_W +: DWORD_W] = {DWORD_W{s1GtD[d]}};
    assign resMadd[d*DWORD_W +: DWORD_W] = s1Prod[2*d] + s1Prod[2*d+1];
  end

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte2
    assign resMaxU[b*BYTE_W +: BYTE_W] = s1GtB[b] ? s1Dst[b*BYTE_W +: BYTE_W]
                                                  : s1Src[b*BYTE_W +: BYTE_W];
  end

  assign extWord = s1Src[s1Idx*WORD_W +: WORD_W];
  assign resExt  = {{(DATA_W-WORD_W){1'b0}}, extWord};

  always_comb begin
    resNext = '0;
    if (strb.sel.cmpW) resNext = resNext | resCmpW;
    if (strb.sel.cmpD) resNext = resNext | resCmpD;
    if (strb.sel.maxS) resNext = resNext | resMaxS;
    if (strb.sel.maxU) resNext = resNext | resMaxU;
    if (strb.sel.ext)  resNext = resNext | resExt;
    if (strb.sel.ins)  resNext = resNext | resIns;
    if (strb.sel.madd) resNext = resNext | resMadd;
  end

  always_ff @(posedge clk) begin
    if (rst)              outResult <= '0;
    else if (strb.retire) outResult <= resNext;
  end

endmodule

// File: rtl/simd_exec.sv
module simd_exec
  import simd_exec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OP_W-1:0]   inOp,
  input  logic [DATA_W-1:0] inDst,
  input  logic [DATA_W-1:0] inSrc,
  input  logic [INT_W-1:0]  inInt,
  input  logic [IMM_W-1:0]  inImm,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);

  simdStrb_t strb;

  simd_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inOp     (inOp),
    .strb     (strb),
    .outValid (outValid)
  );

  simd_dp i_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .inDst     (inDst),
    .inSrc     (inSrc),
    .inInt     (inInt),
    .inImm     (inImm),
    .outResult (outResult)
  );

endmodule

// File: rtl/simd_exec_chk.sv
module simd_exec_chk
  import simd_exec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OP_W-1:0]   inOp,
  input logic [DATA_W-1:0] inDst,
  input logic [DATA_W-1:0] inSrc,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult
);

  logic [OP_W-1:0]   opD1, opD2;
  logic [DATA_W-1:0] dstD1, dstD2, srcD1, srcD2;

  always_ff @(posedge clk) begin
    opD1  <= inOp;   opD2  <= opD1;
    dstD1 <= inDst;  dstD2 <= dstD1;
    srcD1 <= inSrc;  srcD2 <= srcD1;
  end

  function automatic logic masksSolid(input logic [DATA_W-1:0] v, input int laneW);
    logic ok = 1'b1;
    for (int i = 0; i < DATA_W / laneW; i++) begin
      logic [DWORD_W-1:0] lane;
      lane = DWORD_W'(v[i*laneW +: DWORD_W] & ((64'd1 << laneW) - 64'd1));
      if (lane != '0 && lane != DWORD_W'((64'd1 << laneW) - 64'd1)) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic maxSOk(input logic [DATA_W-1:0] r, d, s);
    logic ok = 1'b1;
    for (int w = 0; w < NUM_WORDS; w++) begin
      logic signed [WORD_W-1:0] rv, dv, sv;
      rv = r[w*WORD_W +: WORD_W]; dv = d[w*WORD_W +: WORD_W]; sv = s[w*WORD_W +: WORD_W];
      if (!((rv == dv || rv == sv) && rv >= dv && rv >= sv)) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic maxUOk(input logic [DATA_W-1:0] r, d, s);
    logic ok = 1'b1;
    for (int b = 0; b < NUM_BYTES; b++) begin
      logic [BYTE_W-1:0] rv, dv, sv;
      rv = r[b*BYTE_W +: BYTE_W]; dv = d[b*BYTE_W +: BYTE_W]; sv = s[b*BYTE_W +: BYTE_W];
      if (!((rv == dv || rv == sv) && rv >= dv && rv >= sv)) ok = 1'b0;
    end
    return ok;
  endfunction

  a_r8_issue_retires: assert property (@(posedge clk) disable iff (rst)
    inValid |=> ##1 outValid);

  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ##1 !outValid);

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && outResult == '0));

  a_r1_dword_masks: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_CMPGT_D) |-> masksSolid(outResult, DWORD_W));

  a_r2_word_masks: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_CMPGT_W) |-> masksSolid(outResult, WORD_W));

  a_r3_signed_max: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_MAX_SW) |-> maxSOk(outResult, dstD2, srcD2));

  a_r4_unsigned_max: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_MAX_UB) |-> maxUOk(outResult, dstD2, srcD2));

  a_r5_extract_zero_ext: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_EXTRACT) |-> outResult[DATA_W-1:WORD_W] == '0);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && opD2 == OP_RESERVED) |-> outResult == '0);

endmodule

bind simd_exec simd_exec_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inOp      (inOp),
  .inDst     (inDst),
  .inSrc     (inSrc),
  .outValid  (outValid),
  .outResult (outResult)
);

// File: tb/test_simd_exec.sv
`timescale 1ns/1ps
module test_simd_exec;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  inOp = '0;
  logic [63:0] inDst = '0, inSrc = '0;
  logic [31:0] inInt = '0;
  logic [7:0]  inImm = '0;
  logic        outValid;
  logic [63:0] outResult;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  simd_exec i_simd_exec (
    .clk(clk), .rst(rst), .inValid(inValid), .inOp(inOp),
    .inDst(inDst), .inSrc(inSrc), .inInt(inInt), .inImm(inImm),
    .outValid(outValid), .outResult(outResult)
  );

  // Model written from the requirements
  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] d, s,
                                        input logic [31:0] iv, input logic [7:0] imm);
    logic [63:0] r = '0;
    int k = int'(imm[1:0]);
    case (op)
      3'd0: for (int w = 0; w < 4; w++)
              r[w*16 +: 16] = ($signed(d[w*16 +: 16]) > $signed(s[w*16 +: 16])) ? 16'hFFFF : 16'h0;
      3'd1: for (int i = 0; i < 2; i++)
              r[i*32 +: 32] = ($signed(d[i*32 +: 32]) > $signed(s[i*32 +: 32])) ? 32'hFFFF_FFFF : 32'h0;
      3'd2: for (int w = 0; w < 4; w++)
              r[w*16 +: 16] = ($signed(d[w*16 +: 16]) > $signed(s[w*16 +: 16])) ? d[w*16 +: 16] : s[w*16 +: 16];
      3'd3: for (int b = 0; b < 8; b++)
              r[b*8 +: 8] = (d[b*8 +: 8] > s[b*8 +: 8]) ? d[b*8 +: 8] : s[b*8 +: 8];
      3'd4: r = {48'h0, s[k*16 +: 16]};
      3'd5: begin r = d; r[k*16 +: 16] = iv[15:0]; end
      3'd6: for (int i = 0; i < 2; i++) begin
              logic signed [31:0] p0, p1;
              p0 = $signed(d[(2*i)*16 +: 16]) * $signed(s[(2*i)*16 +: 16]);
              p1 = $signed(d[(2*i+1)*16 +: 16]) * $signed(s[(2*i+1)*16 +: 16]);
              r[i*32 +: 32] = p0 + p1;
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2"; 3'd1: return "R1"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R10";
    endcase
  endfunction

  // Expected pipeline: slot 0 issued last negedge, slot 1 the one before
  logic        pv [2] = '{1'b0, 1'b0};
  logic [63:0] pr [2];
  string       pt [2];

  task automatic checkOut();
    checks++;
    if (outValid !== pv[1]) begin
      failures++;
      $display("FAIL R8 outValid actual=%0b expected=%0b", outValid, pv[1]);
    end
    if (pv[1]) begin
      checks++;
      if (outResult !== pr[1]) begin
        failures++;
        $display("FAIL %s result actual=%h expected=%h", pt[1], outResult, pr[1]);
      end
    end
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [63:0] d, s,
                      input logic [31:0] iv, input logic [7:0] imm);
    @(negedge clk);
    checkOut();
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    pv[0] = v; pr[0] = model(op, d, s, iv, imm); pt[0] = tagOf(op);
    inValid = v; inOp = op; inDst = d; inSrc = s; inInt = iv; inImm = imm;
  endtask

  task automatic resetPulse();
    @(negedge clk);
    checkOut();
    rst = 1'b1; inValid = 1'b1; inOp = 3'd5;
    pv[0] = 1'b0; pv[1] = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outResult !== 64'h0) begin
      failures++;
      $display("FAIL R9 after reset actual=%0b/%h expected=0/0", outValid, outResult);
    end
    rst = 1'b0; inValid = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || outResult !== 64'h0) begin
        failures++;
        $display("FAIL R9 reset state actual=%0b/%h expected=0/0", outValid, outResult);
      end
    end
    rst = 1'b0;

    // Directed corner cases
    step(1, 3'd6, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 0, 0); // R7 wrap
    step(1, 3'd6, 64'h0003_FFFF_7FFF_0002, 64'h0004_0005_7FFF_FFFD, 0, 0); // R7 mixed
    step(1, 3'd0, 64'h8000_7FFF_1234_0001, 64'h7FFF_8000_1234_FFFF, 0, 0); // R2 signed
    step(1, 3'd1, 64'h8000_0000_0000_0005, 64'h7FFF_FFFF_0000_0005, 0, 0); // R1 equal/neg
    step(1, 3'd2, 64'h8000_7FFF_FFFF_0000, 64'h7FFF_8000_0001_0000, 0, 0); // R3
    step(1, 3'd3, 64'hFF01_7F80_0000_AA55, 64'h01FF_807F_0000_55AA, 0, 0); // R4 unsigned
    step(1, 3'd4, 64'h0, 64'hDDDD_CCCC_BBBB_AAAA, 0, 8'hFE);              // R5 idx 2, high imm ignored
    step(1, 3'd5, 64'h4444_3333_2222_1111, 64'h0, 32'hABCD_1234, 8'h07);  // R6 idx 3, int high ignored
    step(1, 3'd5, 64'h4444_3333_2222_1111, 64'h0, 32'hFFFF_0000, 8'hF0);  // R6 idx 0
    step(1, 3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 32'hFFFF_FFFF, 8'hFF);  // R10
    step(0, 3'd0, 0, 0, 0, 0);                                            // R8 idle gap
    step(1, 3'd4, 64'h0, 64'h8765_4321_0FED_CBA9, 0, 8'h01);              // R5 idx 1

    // Constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d, s;
      logic [2:0]  op;
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) s = d ^ (64'h1 << $urandom_range(0, 63));
      if ($urandom_range(0, 7) == 0) d = 64'h8000_8000_8000_8000;
      op = 3'($urandom_range(0, 7));
      step($urandom_range(0, 4) != 0, op, d, s, $urandom, 8'($urandom));
      if (n == 1500) resetPulse(); // R9 mid-stream
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule